// File: doc/BRIEF.md
# Dual-Lane Serial Converter Capture Controller

This block is the host side of a link to a pair of simultaneously sampling serial converters. When it starts a frame, it drives an active-low select and a serial clock. It shifts in two data lines, one per converter, side by side under that one clock. When the frame ends, it presents a pair of 12-bit results together with a one-cycle strobe. The falling edge of the select is the sampling instant. There is no pipeline latency, so the results of a frame come from that frame's own sample.

A frame runs for 16 clocks by default, or 14 clocks when the short-frame input is set. The result always occupies the last 12 bits shifted in. Any leading bits are discarded, which has the same effect as zero-filling the upper positions. A coding input chooses how each result is presented: unchanged as straight binary, or with its top bit inverted so that it reads as a signed two's-complement value.

A power-down request sends a truncated burst of 8 clocks instead of a full frame. After the burst, a status output stays high until the next full frame begins.

Top module: `dual_adc_capture`

## Requirements
- R1: While reset is held and right after it: select high, serial clock high, strobe low, power-down status low, busy low.
- R2: A start request is honoured only while idle, and the select falls on the next clock edge. A start request during a frame or during the inter-frame gap is ignored: no extra frame follows.
- R3: Both data lines are captured at every rising edge of the serial clock, most significant bit first. One frame yields one result per lane, and both results come from that same frame.
- R4: A frame has exactly 16 serial-clock cycles when the short-frame input is 0, and 14 when it is 1. The input is read at the start request.
- R5: Each result equals the last 12 bits captured in the frame. The leading 4 bits (16-clock frame) or 2 bits (14-clock frame) have no effect on the result.
- R6: With the coding input at 0, a result is the captured 12 bits unchanged. With it at 1, bit 11 is inverted. The coding input is read at the start request.
- R7: The strobe is high for exactly one system clock after each full frame, in the cycle in which the select rises. It never fires for a power-down burst.
- R8: The serial clock sits high whenever the select is high. The select stays high for at least one serial-clock period (2×HALF_DIV system cycles) between frames.
- R9: A power-down request while idle produces a burst of exactly 8 serial clocks with no strobe. The power-down status then goes high and stays high until a full frame starts.
- R10: A power-down request that is not idle is ignored. When a start request and a power-down request arrive together while idle, the start request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a full conversion frame |
| pdn_req_i | input | 1 | Request a power-down burst |
| frame14_i | input | 1 | 1 selects the 14-clock frame |
| twos_i | input | 1 | 1 selects two's-complement coding |
| sdata_a_i | input | 1 | Serial data from converter A |
| sdata_b_i | input | 1 | Serial data from converter B |
| cs_n_o | output | 1 | Active-low select / frame sync |
| sclk_o | output | 1 | Serial clock, parked high |
| res_a_o | output | 12 | Result of lane A |
| res_b_o | output | 12 | Result of lane B |
| valid_o | output | 1 | One-cycle result strobe |
| pdn_o | output | 1 | Converter is in power-down |
| busy_o | output | 1 | Frame, burst or gap in progress |

## Verification
The assertions check the following on every cycle:
- the serial clock is parked high while the select is high;
- the strobe is a single-cycle pulse and never coincides with power-down status;
- a frame only begins from idle;
- the inter-frame gap is long enough;
- the number of rising clock edges in each frame matches the latched length.

Only the bench's scenarios can show the rest:
- the captured values and the discarding of leading bits;
- the coding;
- the exact burst length of a power-down;
- the ignoring of requests made while busy;
- the priority of start over power-down.

The bench does this by sweeping result values across both frame lengths and both codings, against a serial converter model.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } cap_state_e;
endpackage

// File: rtl/adc_cap_tick.sv
module adc_cap_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (HALF_DIV > 1) begin : g_spacing
      p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/adc_cap_lane.sv
module adc_cap_lane #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en_i,
  input  logic             sdat_i,
  output logic [RES_W-1:0] word_o
);
  logic [RES_W-1:0] sh_q;

  // the word including the bit being captured this cycle
  assign word_o = {sh_q[RES_W-2:0], sdat_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sh_q <= '0;
    else if (shift_en_i) sh_q <= word_o;
  end
endmodule

// File: rtl/dual_adc_capture.sv
module dual_adc_capture
  import adc_cap_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int RES_W     = 12,
  parameter int LONG_LEN  = 16,
  parameter int SHORT_LEN = 14,
  parameter int PDN_LEN   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pdn_req_i,
  input  logic             frame14_i,
  input  logic             twos_i,
  input  logic             sdata_a_i,
  input  logic             sdata_b_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic [RES_W-1:0] res_a_o,
  output logic [RES_W-1:0] res_b_o,
  output logic             valid_o,
  output logic             pdn_o,
  output logic             busy_o
);
  localparam int LANES = 2;
  localparam int CW    = $clog2(LONG_LEN + 1);
  localparam logic [CW-1:0] L_LONG  = CW'(LONG_LEN);
  localparam logic [CW-1:0] L_SHORT = CW'(SHORT_LEN);
  localparam logic [CW-1:0] L_PDN   = CW'(PDN_LEN);
  localparam logic [RES_W-1:0] SIGN_FLIP = {1'b1, {(RES_W-1){1'b0}}};

  cap_state_e       state_q, state_d;
  logic             sclk_q, sclk_d, cs_n_q, cs_n_d;
  logic [CW-1:0]    bit_q, bit_d, len_q, len_d;
  logic             burst_q, burst_d, twos_q, twos_d;
  logic             valid_q, valid_d, pd_q, pd_d;
  logic [RES_W-1:0] ra_q, ra_d, rb_q, rb_d;
  logic             tick, shift_en, last_bit;
  logic [RES_W-1:0] word [LANES];
  logic [LANES-1:0] sdat;

  assign sdat = {sdata_b_i, sdata_a_i};

  adc_cap_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(state_q != ST_IDLE), .tick_o(tick)
  );

  assign shift_en = (state_q == ST_SHIFT) && tick && !sclk_q;
  assign last_bit = (bit_q == len_q - 1'b1);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      adc_cap_lane #(.RES_W(RES_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .shift_en_i(shift_en),
        .sdat_i(sdat[g]), .word_o(word[g])
      );
    end
  endgenerate

  always_comb begin
    state_d = state_q;  sclk_d  = sclk_q;  cs_n_d = cs_n_q;
    bit_d   = bit_q;    len_d   = len_q;   burst_d = burst_q;
    twos_d  = twos_q;   pd_d    = pd_q;    valid_d = 1'b0;
    ra_d    = ra_q;     rb_d    = rb_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SHIFT; cs_n_d = 1'b0; bit_d = '0; burst_d = 1'b0;
          len_d   = frame14_i ? L_SHORT : L_LONG;
          twos_d  = twos_i;   pd_d = 1'b0;
        end else if (pdn_req_i) begin
          state_d = ST_SHIFT; cs_n_d = 1'b0; bit_d = '0; burst_d = 1'b1;
          len_d   = L_PDN;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (sclk_q) begin
            sclk_d = 1'b0;
          end else begin
            sclk_d = 1'b1;
            bit_d  = bit_q + 1'b1;
            if (last_bit) begin
              state_d = ST_GAP; cs_n_d = 1'b1; bit_d = '0;
              if (burst_q) begin
                pd_d = 1'b1;
              end else begin
                valid_d = 1'b1;
                ra_d = word[0] ^ (twos_q ? SIGN_FLIP : '0);
                rb_d = word[1] ^ (twos_q ? SIGN_FLIP : '0);
              end
            end
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          bit_d = bit_q + 1'b1;
          if (bit_q == CW'(1)) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; sclk_q <= 1'b1; cs_n_q <= 1'b1;
      bit_q   <= '0;      len_q  <= L_LONG; burst_q <= 1'b0;
      twos_q  <= 1'b0;    pd_q   <= 1'b0;   valid_q <= 1'b0;
      ra_q    <= '0;      rb_q   <= '0;
    end else begin
      state_q <= state_d; sclk_q <= sclk_d; cs_n_q <= cs_n_d;
      bit_q   <= bit_d;   len_q  <= len_d;  burst_q <= burst_d;
      twos_q  <= twos_d;  pd_q   <= pd_d;   valid_q <= valid_d;
      ra_q    <= ra_d;    rb_q   <= rb_d;
    end
  end

  assign cs_n_o  = cs_n_q;
  assign sclk_o  = sclk_q;
  assign res_a_o = ra_q;
  assign res_b_o = rb_q;
  assign valid_o = valid_q;
  assign pdn_o   = pd_q;
  assign busy_o  = (state_q != ST_IDLE);

  // checker state: rising serial edges in a frame and select-high run length
  logic          sclk_d1;
  logic [CW-1:0] rise_cnt;
  logic [7:0]    high_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d1 <= 1'b1; rise_cnt <= '0; high_cnt <= '1;
    end else begin
      sclk_d1 <= sclk_o;
      if (cs_n_o)                 rise_cnt <= '0;
      else if (sclk_o && !sclk_d1) rise_cnt <= rise_cnt + 1'b1;
      if (!cs_n_o)                high_cnt <= '0;
      else if (high_cnt != '1)    high_cnt <= high_cnt + 1'b1;
    end
  end

  p_sclk_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);
  p_gap_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (high_cnt >= 8'(2*HALF_DIV)));
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_valid_not_pdn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !pdn_o);
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !$past(busy_o));
  p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((rise_cnt + 1'b1) == len_q));
endmodule

// File: tb/tb_dual_adc_capture.sv
module tb_dual_adc_capture;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, pdn_req_i = 0, frame14_i = 0, twos_i = 0;
  logic sda = 0, sdb = 0;
  logic cs_n_o, sclk_o, valid_o, pdn_o, busy_o;
  logic [11:0] res_a_o, res_b_o;

  int n_chk = 0, n_bad = 0, vcount = 0, fcnt = 0, mdl_n = 16;
  logic [31:0] mdl_a = 0, mdl_b = 0;
  bit done = 0;
  int gap_run = 0, min_gap = 1000;
  bit seen_frame = 0;

  always #2 clk = ~clk;

  dual_adc_capture dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pdn_req_i(pdn_req_i),
    .frame14_i(frame14_i), .twos_i(twos_i), .sdata_a_i(sda), .sdata_b_i(sdb),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .res_a_o(res_a_o), .res_b_o(res_b_o),
    .valid_o(valid_o), .pdn_o(pdn_o), .busy_o(busy_o)
  );

  // converter model: new bit after each falling serial edge, MSB first
  always @(negedge cs_n_o or negedge sclk_o) begin
    if (!cs_n_o) begin
      if (sclk_o) begin
        fcnt = 0; sda = 0; sdb = 0;
      end else begin
        fcnt = fcnt + 1;
        if (fcnt <= mdl_n) begin
          sda = mdl_a[mdl_n - fcnt];
          sdb = mdl_b[mdl_n - fcnt];
        end
      end
    end
  end

  always @(posedge clk) begin
    if (valid_o) vcount++;
    if (rst_n) begin
      if (cs_n_o) gap_run++;
      else begin
        if (seen_frame && gap_run > 0 && gap_run < min_gap) min_gap = gap_run;
        if (gap_run > 0) seen_frame = 1;
        gap_run = 0;
      end
    end
  end

  task automatic chk(string tag, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy_o && t < 1000) begin @(negedge clk); t++; end
  endtask

  task automatic frame(bit f14, bit tw, logic [11:0] a, logic [11:0] b,
                       logic [3:0] lead);
    int t = 0;
    int n;
    logic [11:0] ea, eb;
    n = f14 ? 14 : 16;
    wait_idle();
    mdl_n = n;
    mdl_a = {16'h0, lead, a};
    mdl_b = {16'h0, ~lead, b};
    @(negedge clk);
    frame14_i = f14; twos_i = tw; start_i = 1;
    @(negedge clk);
    start_i = 0; frame14_i = ~f14; twos_i = ~tw;
    while (!valid_o && t < 500) begin @(negedge clk); t++; end
    ea = a ^ (tw ? 12'h800 : 12'h0);
    eb = b ^ (tw ? 12'h800 : 12'h0);
    chk("R3/R5/R6 lane A", res_a_o == ea, res_a_o, ea);
    chk("R3/R5/R6 lane B", res_b_o == eb, res_b_o, eb);
    chk("R4 serial clocks per frame", fcnt == n, fcnt, n);
    chk("R7 strobe with select high", valid_o && cs_n_o, valid_o, 1);
    @(negedge clk);
    chk("R7 strobe single cycle", !valid_o, valid_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", cs_n_o == 1, cs_n_o, 1);
    chk("R1 sclk", sclk_o == 1, sclk_o, 1);
    chk("R1 valid", valid_o == 0, valid_o, 0);
    chk("R1 pdn", pdn_o == 0, pdn_o, 0);
    chk("R1 busy", busy_o == 0, busy_o, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: select falls on the edge right after the start request
    start_i = 1; mdl_n = 16;
    @(negedge clk);
    start_i = 0;
    chk("R2 select falls next edge", cs_n_o == 0, cs_n_o, 0);
    wait_idle();

    // sweep values over both frame lengths and both codings
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int v = 0; v < 4096; v += 97) begin
        frame(cfg[0], cfg[1], 12'(v), 12'(4095 - ((v * 3) % 4096)), 4'(v));
      end
      frame(cfg[0], cfg[1], 12'hFFF, 12'h000, 4'hF);
      frame(cfg[0], cfg[1], 12'h800, 12'h7FF, 4'h0);
    end

    // R2: start during a frame is ignored
    wait_idle();
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
    repeat (10) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R2 no extra frame", cs_n_o == 1 && !busy_o, cs_n_o, 1);

    // R8: back-to-back frames with start held high
    v0 = vcount;
    start_i = 1;
    repeat (3) begin
      int t = 0;
      @(negedge clk);
      while (!valid_o && t < 500) begin @(negedge clk); t++; end
    end
    start_i = 0;
    wait_idle();
    chk("R8 back-to-back frames", vcount - v0 >= 3, vcount - v0, 3);
    chk("R8 minimum select-high gap", min_gap >= 2 * HALF, min_gap, 2 * HALF);

    // R9: power-down burst
    v0 = vcount; mdl_n = 8;
    @(negedge clk); pdn_req_i = 1; @(negedge clk); pdn_req_i = 0;
    chk("R9 burst starts", cs_n_o == 0, cs_n_o, 0);
    wait_idle();
    chk("R9 burst length", fcnt == 8, fcnt, 8);
    chk("R9 no strobe on burst", vcount == v0, vcount, v0);
    chk("R9 status set", pdn_o == 1, pdn_o, 1);

    // R10: power-down request during a frame is ignored
    frame(0, 0, 12'h5A5, 12'hA5A, 4'h3);
    chk("R9 status cleared by frame", pdn_o == 0, pdn_o, 0);
    wait_idle();
    mdl_n = 16;
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
    repeat (6) @(negedge clk);
    pdn_req_i = 1; @(negedge clk); pdn_req_i = 0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R10 busy request ignored", pdn_o == 0 && cs_n_o, pdn_o, 0);

    // R10: simultaneous start and power-down: start wins
    v0 = vcount; mdl_a = 32'h0123; mdl_b = 32'h0456;
    @(negedge clk); start_i = 1; pdn_req_i = 1; frame14_i = 0; twos_i = 0;
    @(negedge clk); start_i = 0; pdn_req_i = 0;
    wait_idle();
    chk("R10 start wins strobe", vcount == v0 + 1, vcount - v0, 1);
    chk("R10 start wins length", fcnt == 16, fcnt, 16);
    chk("R10 start wins value", res_a_o == 12'h123, res_a_o, 12'h123);
    chk("R10 no power-down", pdn_o == 0, pdn_o, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule